// File: doc/BRIEF.md
# Dual-Mode SPI Clock Divider

This block turns a fast module clock into the serial clock of an SPI shift engine. A configuration word chooses between two division schemes. The linear scheme divides by an even count taken from an 8-bit field. The exponent scheme divides by a power of two taken from a 4-bit field. Alongside the registered serial clock, the block gives one-cycle strobes that mark each rising and each falling edge of that clock. The shift engine uses these strobes to launch and capture data in the module clock domain.

The block runs only while its run input is high. While run is low, the counter is held at zero, no strobes come out, and the serial clock sits at the idle level the caller gives. Settings are copied into a shadow register only while the block is idle, so a change made during a transfer waits for the next start. Each half period has the same number of module cycles, so the duty cycle is always 50%. The serial clock comes straight from a flop and has no glitches.

Top module: `spi_clkdiv`

## Requirements
- R1: With the mode bit (cfg_word bit 12) set to 1, the serial clock period is 2×(n+1) module clock cycles, where n is cfg_word[7:0] (0..255, so the division runs from 2 to 512).
- R2: With the mode bit at 0 and the exponent n = cfg_word[11:8] in the range 1..15, the serial clock period is 2^n module clock cycles.
- R3: With the mode bit at 0 and exponent 0, the serial clock toggles on every module clock cycle. Rising and falling strobes then alternate on consecutive cycles, and the period is 2 cycles.
- R4: High and low phases are equal: each lasts exactly half of the period from R1/R2/R3.
- R5: On every clock edge at which run is low, sck takes the value of idle_level, both strobes go to 0 and the counter clears. When run goes low in the middle of a phase, sck returns to idle on the next edge with no strobe.
- R6: The divider setting is the cfg_word value sampled at the last clock edge at which run was low. Changes to cfg_word while run is high have no effect until run has gone low and high again.
- R7: rise_tick is 1 for exactly the one cycle in which sck has just changed from 0 to 1. fall_tick is 1 for exactly the one cycle in which sck has just changed from 1 to 0. No strobe is given in any other cycle.
- R8: Counting the first edge at which run is sampled high as edge 1, sck first changes after edge H, where H is the half period in module cycles.
- R9: With idle_level at 1, the first serial edge after start is a falling edge and the clock returns to 1 when stopped.
- R10: While rst_n is low, sck, rise_tick and fall_tick are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | High to generate the serial clock; low holds it idle |
| cfg_word | input | LIN_W+EXP_W+1 (13) | [7:0] linear count, [11:8] exponent, [12] mode select (1 = linear) |
| idle_level | input | 1 | Level of sck while not running (clock polarity) |
| sck | output | 1 | Registered serial clock |
| rise_tick | output | 1 | One-cycle strobe: sck just rose |
| fall_tick | output | 1 | One-cycle strobe: sck just fell |

## Verification
The bench goes after the ends of both ranges. Linear count 0 and exponent 1 both give a divide-by-two, and linear count 255 gives the widest half period. An off-by-one in either formula would show up as a wrong edge index there. Exponent 0 is the degenerate case. A decoder that shifted by n-1 without a special case would wrap to a huge count, and the bench would see no edges at all. A cfg_word change in the middle of a transfer checks the shadow capture: a design that decoded the live word would move its edges early. Stopping in the high phase, then restarting with idle level 1, checks that the counter clears and that the polarity is honoured. A design that kept a stale count or state would give a short first phase or a stray strobe.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;

   // Division scheme selected by the mode bit of the configuration word
   typedef enum logic {
      DIV_EXP = 1'b0,   // module clock / 2^n
      DIV_LIN = 1'b1    // module clock / (2*(n+1))
   } div_mode_e;

   // Bits needed for the largest half period of each scheme
   function automatic int lin_half_bits(input int lin_w);
      return lin_w + 1;
   endfunction

   function automatic int exp_half_bits(input int exp_w);
      return (1 << exp_w) - 1;
   endfunction

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/spi_clkdiv_shadow.sv
module spi_clkdiv_shadow
   import spi_clkdiv_pkg::*;
#(
   parameter int LIN_W = 8,
   parameter int EXP_W = 4,
   localparam int CFG_W   = LIN_W + EXP_W + 1,
   localparam int LIN_LSB = 0,
   localparam int EXP_LSB = LIN_W,
   localparam int SEL_POS = LIN_W + EXP_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CFG_W-1:0] cfg_word,
   output div_mode_e        mode_q,
   output logic [LIN_W-1:0] lin_q,
   output logic [EXP_W-1:0] exp_q
);

   logic [LIN_W-1:0] lin_field;
   logic [EXP_W-1:0] exp_field;
   div_mode_e        mode_field;

   always_comb begin
      lin_field  = cfg_word[LIN_LSB +: LIN_W];
      exp_field  = cfg_word[EXP_LSB +: EXP_W];
      mode_field = div_mode_e'(cfg_word[SEL_POS]);
   end

   // Capture only while idle; hold for the whole transfer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= DIV_EXP;
         lin_q  <= '0;
         exp_q  <= '0;
      end else if (!run) begin
         mode_q <= mode_field;
         lin_q  <= lin_field;
         exp_q  <= exp_field;
      end
   end

endmodule

// File: rtl/spi_clkdiv_rate.sv
module spi_clkdiv_rate
   import spi_clkdiv_pkg::*;
#(
   parameter int LIN_W  = 8,
   parameter int EXP_W  = 4,
   parameter int HALF_W = 15,
   localparam int EXP_STEPS = (1 << EXP_W)
) (
   input  div_mode_e         mode,
   input  logic [LIN_W-1:0]  lin_n,
   input  logic [EXP_W-1:0]  exp_n,
   output logic [HALF_W-1:0] half
);

   logic [HALF_W-1:0] lin_half;
   logic [HALF_W-1:0] exp_half;

   // Linear scheme: half period is n+1 module cycles
   always_comb begin
      lin_half = HALF_W'(lin_n) + HALF_W'(1);
   end

   // Exponent scheme: half period is 2^(n-1); exponent 0 and 1 both give 1
   // Built as a one-hot decode, one generated term per bit position
   generate
      for (genvar b = 0; b < HALF_W; b++) begin : g_pow
         if (b == 0) begin : g_lsb
            assign exp_half[b] = (exp_n == EXP_W'(0)) || (exp_n == EXP_W'(1));
         end else if (b + 1 < EXP_STEPS) begin : g_mid
            assign exp_half[b] = (exp_n == EXP_W'(b + 1));
         end else begin : g_top
            assign exp_half[b] = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      half = (mode == DIV_LIN) ? lin_half : exp_half;
   end

endmodule

// File: rtl/spi_clkdiv_gen.sv
module spi_clkdiv_gen #(
   parameter int HALF_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              idle_level,
   input  logic [HALF_W-1:0] half,
   output logic              sck,
   output logic              rise_tick,
   output logic              fall_tick
);

   logic [HALF_W-1:0] phase_cnt;
   logic              phase_end;

   always_comb begin
      phase_end = (phase_cnt == (half - HALF_W'(1)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_cnt <= '0;
         sck       <= 1'b0;
         rise_tick <= 1'b0;
         fall_tick <= 1'b0;
      end else if (!run) begin
         phase_cnt <= '0;
         sck       <= idle_level;
         rise_tick <= 1'b0;
         fall_tick <= 1'b0;
      end else if (phase_end) begin
         phase_cnt <= '0;
         sck       <= ~sck;
         rise_tick <= ~sck;
         fall_tick <= sck;
      end else begin
         phase_cnt <= phase_cnt + HALF_W'(1);
         rise_tick <= 1'b0;
         fall_tick <= 1'b0;
      end
   end

endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv
   import spi_clkdiv_pkg::*;
#(
   parameter int LIN_W = 8,
   parameter int EXP_W = 4,
   localparam int CFG_W  = LIN_W + EXP_W + 1,
   localparam int HALF_W = max_int(lin_half_bits(LIN_W), exp_half_bits(EXP_W))
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CFG_W-1:0] cfg_word,
   input  logic             idle_level,
   output logic             sck,
   output logic             rise_tick,
   output logic             fall_tick
);

   // Elaboration-time parameter checks
   generate
      if (LIN_W < 1 || LIN_W > 16) begin : g_bad_lin
         $error("spi_clkdiv: LIN_W must lie in 1..16");
      end
      if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp
         $error("spi_clkdiv: EXP_W must lie in 1..5");
      end
   endgenerate

   div_mode_e         mode_q;
   logic [LIN_W-1:0]  lin_q;
   logic [EXP_W-1:0]  exp_q;
   logic [HALF_W-1:0] half;

   spi_clkdiv_shadow #(
      .LIN_W (LIN_W),
      .EXP_W (EXP_W)
   ) u_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .cfg_word (cfg_word),
      .mode_q   (mode_q),
      .lin_q    (lin_q),
      .exp_q    (exp_q)
   );

   spi_clkdiv_rate #(
      .LIN_W  (LIN_W),
      .EXP_W  (EXP_W),
      .HALF_W (HALF_W)
   ) u_rate (
      .mode  (mode_q),
      .lin_n (lin_q),
      .exp_n (exp_q),
      .half  (half)
   );

   spi_clkdiv_gen #(
      .HALF_W (HALF_W)
   ) u_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .idle_level (idle_level),
      .half       (half),
      .sck        (sck),
      .rise_tick  (rise_tick),
      .fall_tick  (fall_tick)
   );

endmodule

// File: rtl/spi_clkdiv_chk.sv
module spi_clkdiv_chk
   import spi_clkdiv_pkg::*;
#(
   parameter int LIN_W = 8,
   parameter int EXP_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             idle_level,
   input logic             sck,
   input logic             rise_tick,
   input logic             fall_tick,
   input div_mode_e        mode_q,
   input logic [LIN_W-1:0] lin_q,
   input logic [EXP_W-1:0] exp_q
);

   // R5: an idle edge parks the clock at the requested level
   p_idle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (sck == $past(idle_level)));

   // R5: no strobes after an idle edge
   p_quiet_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!rise_tick && !fall_tick));

   // R7: a rising strobe marks a real 0->1 step of sck
   p_rise_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rise_tick |-> (sck && !$past(sck)));

   // R7: a falling strobe marks a real 1->0 step of sck
   p_fall_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fall_tick |-> (!sck && $past(sck)));

   // R7: while running, every sck change carries a strobe
   p_edge_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run) && (sck != $past(sck))) |-> (rise_tick || fall_tick));

   // R6: shadowed settings stay frozen across running edges
   p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(run) |-> $stable({mode_q, exp_q, lin_q}));

endmodule

bind spi_clkdiv spi_clkdiv_chk #(
   .LIN_W (LIN_W),
   .EXP_W (EXP_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .run        (run),
   .idle_level (idle_level),
   .sck        (sck),
   .rise_tick  (rise_tick),
   .fall_tick  (fall_tick),
   .mode_q     (mode_q),
   .lin_q      (lin_q),
   .exp_q      (exp_q)
);

// File: tb/spi_clkdiv_test.sv
`timescale 1ns/1ps
module spi_clkdiv_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic [12:0] cfg_word = '0;
   logic        idle_level = 1'b0;
   logic        sck;
   logic        rise_tick;
   logic        fall_tick;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   spi_clkdiv uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .cfg_word   (cfg_word),
      .idle_level (idle_level),
      .sck        (sck),
      .rise_tick  (rise_tick),
      .fall_tick  (fall_tick)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // Expected half period from the division formulas
   function automatic int half_of(input logic [12:0] w);
      int n;
      if (w[12]) return int'(w[7:0]) + 1;
      n = int'(w[11:8]);
      if (n == 0) return 1;
      return (1 << n) / 2;
   endfunction

   function automatic logic [12:0] lin_cfg(input int n);
      return {1'b1, 4'd0, 8'(n)};
   endfunction

   function automatic logic [12:0] exp_cfg(input int n);
      return {1'b0, 4'(n), 8'd0};
   endfunction

   // Start the divider, watch four sck changes, then stop it.
   // If late is set, cfg_word is changed to late_w after the first edge.
   task automatic measure(input logic [12:0] w, input logic idl, input string req,
                          input bit late, input logic [12:0] late_w);
      int   half;
      int   seen;
      int   stray;
      logic prev;
      half = half_of(w);
      @(negedge clk);
      run        = 1'b0;
      cfg_word   = w;
      idle_level = idl;
      repeat (3) @(negedge clk);
      check(sck == idl, "R5", "idle level before start", sck, idl);
      run   = 1'b1;
      seen  = 0;
      stray = 0;
      prev  = idl;
      for (int k = 1; k <= 4 * half + 4 && seen < 4; k++) begin
         @(negedge clk);
         if (sck != prev) begin
            seen++;
            if (seen == 1) begin
               check(k == half, {req, " R8"}, "first edge index", k, half);
               if (idl) check(sck == 1'b0, "R9", "first edge direction", sck, 0);
               if (late) cfg_word = late_w;
            end else begin
               check(k == seen * half, {req, " R4"}, "edge index", k, seen * half);
            end
            if (sck) check(rise_tick && !fall_tick, "R7", "strobes on rise",
                           {rise_tick, fall_tick}, 2);
            else     check(fall_tick && !rise_tick, "R7", "strobes on fall",
                           {rise_tick, fall_tick}, 1);
            prev = sck;
         end else if (rise_tick || fall_tick) begin
            stray++;
         end
      end
      check(seen == 4, req, "edges observed", seen, 4);
      check(stray == 0, "R7", "strobes without an edge", stray, 0);
      run = 1'b0;
      @(negedge clk);
      check(sck == idl && !rise_tick && !fall_tick, "R5", "stop returns idle",
            {sck, rise_tick, fall_tick}, {idl, 2'b00});
   endtask

   // Stop in the middle of a high phase and watch for quiet idle
   task automatic stop_mid_phase();
      int stray;
      @(negedge clk);
      cfg_word   = lin_cfg(3);
      idle_level = 1'b0;
      repeat (2) @(negedge clk);
      run = 1'b1;
      repeat (5) @(negedge clk);   // rose after edge 4, still high
      check(sck == 1'b1, "R5", "high before stop", sck, 1);
      run = 1'b0;
      stray = 0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (sck != 1'b0 || rise_tick || fall_tick) stray++;
      end
      check(stray == 0, "R5", "cycles off idle after mid-phase stop", stray, 0);
   endtask

   task automatic reset_state();
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      check(sck == 1'b0 && !rise_tick && !fall_tick, "R10", "outputs in reset",
            {sck, rise_tick, fall_tick}, 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      reset_state();
      measure(lin_cfg(0),   1'b0, "R1", 1'b0, '0);
      measure(lin_cfg(2),   1'b0, "R1", 1'b0, '0);
      measure(lin_cfg(9),   1'b1, "R1", 1'b0, '0);
      measure(lin_cfg(255), 1'b0, "R1", 1'b0, '0);
      measure(exp_cfg(0),   1'b0, "R3", 1'b0, '0);
      measure(exp_cfg(0),   1'b1, "R3", 1'b0, '0);
      measure(exp_cfg(1),   1'b0, "R2", 1'b0, '0);
      measure(exp_cfg(3),   1'b0, "R2", 1'b0, '0);
      measure(exp_cfg(7),   1'b1, "R2", 1'b0, '0);
      measure(exp_cfg(12),  1'b0, "R2", 1'b0, '0);
      // R6: change during the run is ignored, then used at the next start
      measure(lin_cfg(2),   1'b0, "R6", 1'b1, lin_cfg(5));
      measure(lin_cfg(5),   1'b0, "R6", 1'b0, '0);
      measure(lin_cfg(4),   1'b0, "R6", 1'b1, exp_cfg(1));
      stop_mid_phase();
      measure(lin_cfg(1),   1'b1, "R9", 1'b0, '0);
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run did not complete actual=1 expected=0");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule